// File: doc/BRIEF.md
# Dual Third-Order Multibit Noise Shaper

This block turns a stream of oversampled, two's-complement audio samples into two streams of 31-level codes. Each code drives one multibit DAC element array. Two separate third-order delta-sigma loops run side by side. Path A is fed the sample as it arrives. Path B is fed the sample negated with saturation. The two code streams are therefore complementary and can be combined into one differential analog output.

Each loop runs only when the modulator-rate strobe is high. The strobe rate is the word-clock rate multiplied by the internal oversampling factor. The loop shapes its quantization error with the transfer function (1 - z^-1)^3. It does this by feeding back its three most recent quantization errors, weighted 3, -3 and +1. These weights are built from shifts and adds, so no multiplier is needed. The quantizer rounds to the nearest step and clamps the result to the code range. Each stored error is saturated to one quantizer step, so a loop driven at full scale cannot run away. A mode pin chooses between 24-bit and 20-bit input words. In 20-bit mode the four least significant bits are dropped.

Top module: `dual_noise_shaper`

## Requirements
- R1: While `rst` is high at a rising clock edge, all stored errors are cleared, both codes become 0 and `code_valid` becomes 0. After reset, a strobe with a zero sample returns code 0 on both paths.
- R2: A strobe (`ns_en` high) at one edge makes `code_valid` high for exactly the following cycle, with updated codes. Without a strobe, `code_valid` is low and both codes hold their values.
- R3: Each code is a 5-bit two's-complement value, and it always stays within -15 to +15.
- R4: Per strobe, with input x and stored errors e1 (newest), e2 and e3, the loop forms u = x - (3·e1 - 3·e2 + e3). The code is q = floor((u + 2^18) / 2^19), clamped to ±15. The new error is q·2^19 - u, saturated to ±2^19. It is stored as e1, and the older errors shift down by one place.
- R5: When `wide_mode` is 0 (20-bit words), bits 3:0 of `sample_in` are treated as zero. When `wide_mode` is 1, all 24 bits are used.
- R6: Path B receives the negation of the (masked) path A input. The value -2^23 maps to +2^23-1.
- R7: For a constant input x, the average code over 512 strobes is within 1 code of x/2^19 on path A, and within 1 code of -x/2^19 on path B.
- R8: A sustained full-scale input at either polarity keeps every stored error within ±2^19, so the codes follow R4 and stay bounded.
- R9: The two paths hold separate loop state. Each path's code depends only on its own input history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ns_en | input | 1 | Modulator-rate strobe |
| sample_in | input | IN_W | Interpolated sample, two's complement, MSB-aligned |
| wide_mode | input | 1 | 1: 24-bit words, 0: 20-bit words |
| code_a | output | CODE_W | In-phase path code, signed |
| code_b | output | CODE_W | Inverted path code, signed |
| code_valid | output | 1 | High for one cycle after each strobe |

## Verification
The hardest state to reach is the saturation of the stored errors. It only happens after the quantizer clamps, and that needs the loop input to pass ±15.5 steps while errors are already present. The stimulus first builds up error history with a busy sine-like pattern. It then holds the sample at each full-scale extreme, including -2^23 which drives path B through the saturating negation. After that it returns to ordinary inputs and a mid-run reset. A behavioural model of the recurrence is compared against every strobe along the way.

// File: rtl/dual_noise_shaper_pkg.sv
package dual_noise_shaper_pkg;
  typedef enum logic {
    WORD_20 = 1'b0,
    WORD_24 = 1'b1
  } word_mode_e;

  localparam int N_PATHS = 2;
  localparam int PATH_IN = 0;
  localparam int PATH_INV = 1;
endpackage

// File: rtl/ns_input_cond.sv
module ns_input_cond #(
  parameter int IN_W = 24,
  parameter int DROP_W = 4
) (
  input  logic signed [IN_W-1:0] din,
  input  logic                   wide_mode,
  output logic signed [IN_W-1:0] dout_pos,
  output logic signed [IN_W-1:0] dout_neg
);
  import dual_noise_shaper_pkg::*;

  localparam logic signed [IN_W-1:0] MOST_NEG = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic signed [IN_W-1:0] MOST_POS = {1'b0, {(IN_W-1){1'b1}}};

  logic signed [IN_W-1:0] masked;

  always_comb begin
    if (word_mode_e'(wide_mode) == WORD_24) masked = din;
    else masked = {din[IN_W-1:DROP_W], {DROP_W{1'b0}}};
    dout_pos = masked;
    if (masked == MOST_NEG) dout_neg = MOST_POS;
    else dout_neg = -masked;
  end
endmodule

// File: rtl/ns_loop.sv
module ns_loop #(
  parameter int IN_W = 24,
  parameter int CODE_W = 5,
  parameter int ORDER = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [IN_W-1:0]   din,
  output logic signed [CODE_W-1:0] code
);
  localparam int SH = IN_W - CODE_W;
  localparam int W = IN_W + 3;
  localparam int QMAX = 2 ** (CODE_W - 1) - 1;
  localparam logic signed [W-1:0] STEP_W = W'(1 << SH);
  localparam logic signed [W-1:0] HALF_W = W'(1 << (SH - 1));
  localparam logic signed [W-1:0] QMAX_W = W'(QMAX);

  logic signed [W-1:0] err_q [ORDER];
  logic signed [W-1:0] fb, u, qf, qc, e_raw, e_sat;

  always_comb begin
    fb = ((err_q[0] <<< 1) + err_q[0]) - ((err_q[1] <<< 1) + err_q[1]) + err_q[2];
    u = W'(din) - fb;
    qf = (u + HALF_W) >>> SH;
    if (qf > QMAX_W) qc = QMAX_W;
    else if (qf < -QMAX_W) qc = -QMAX_W;
    else qc = qf;
    e_raw = (qc <<< SH) - u;
    if (e_raw > STEP_W) e_sat = STEP_W;
    else if (e_raw < -STEP_W) e_sat = -STEP_W;
    else e_sat = e_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ORDER; k++) err_q[k] <= '0;
      code <= '0;
    end else if (en) begin
      err_q[0] <= e_sat;
      for (int k = 1; k < ORDER; k++) err_q[k] <= err_q[k-1];
      code <= qc[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/dual_noise_shaper.sv
module dual_noise_shaper #(
  parameter int IN_W = 24,
  parameter int CODE_W = 5,
  parameter int DROP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ns_en,
  input  logic [IN_W-1:0]   sample_in,
  input  logic              wide_mode,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              code_valid
);
  import dual_noise_shaper_pkg::*;

  logic signed [IN_W-1:0]   path_in   [N_PATHS];
  logic signed [CODE_W-1:0] path_code [N_PATHS];

  ns_input_cond #(.IN_W(IN_W), .DROP_W(DROP_W)) u_cond (
    .din       (signed'(sample_in)),
    .wide_mode (wide_mode),
    .dout_pos  (path_in[PATH_IN]),
    .dout_neg  (path_in[PATH_INV])
  );

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    ns_loop #(.IN_W(IN_W), .CODE_W(CODE_W), .ORDER(3)) u_loop (
      .clk  (clk),
      .rst  (rst),
      .en   (ns_en),
      .din  (path_in[p]),
      .code (path_code[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) code_valid <= 1'b0;
    else code_valid <= ns_en;
  end

  assign code_a = path_code[PATH_IN];
  assign code_b = path_code[PATH_INV];
endmodule

// File: rtl/dual_noise_shaper_chk.sv
module dual_noise_shaper_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ns_en,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              code_valid
);
  localparam int QMAX = 2 ** (CODE_W - 1) - 1;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (code_a == '0 && code_b == '0 && !code_valid));

  p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    ns_en |=> code_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ns_en |=> (!code_valid && $stable(code_a) && $stable(code_b)));

  p_code_span_r3: assert property (@(posedge clk) disable iff (rst)
    ($signed(code_a) <= QMAX && $signed(code_a) >= -QMAX &&
     $signed(code_b) <= QMAX && $signed(code_b) >= -QMAX));
endmodule

bind dual_noise_shaper dual_noise_shaper_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ns_en      (ns_en),
  .code_a     (code_a),
  .code_b     (code_b),
  .code_valid (code_valid)
);

// File: tb/dual_noise_shaper_bench.sv
module dual_noise_shaper_bench;
  localparam int IN_W = 24;
  localparam int CODE_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ns_en = 1'b0;
  logic [IN_W-1:0] sample_in = '0;
  logic wide_mode = 1'b1;
  logic [CODE_W-1:0] code_a, code_b;
  logic code_valid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  longint m_err [2][3];
  longint sum_a, sum_b;

  always #2 clk = ~clk;

  dual_noise_shaper u_dual_noise_shaper (
    .clk(clk), .rst(rst), .ns_en(ns_en), .sample_in(sample_in),
    .wide_mode(wide_mode), .code_a(code_a), .code_b(code_b), .code_valid(code_valid)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 3; k++) m_err[p][k] = 0;
  endtask

  task automatic model_step(input int p, input longint x, output longint q);
    longint u, e;
    u = x - (3 * m_err[p][0] - 3 * m_err[p][1] + m_err[p][2]);
    q = (u + (64'sd1 <<< 18)) >>> 19;
    if (q > 15) q = 15;
    if (q < -15) q = -15;
    e = q * (64'sd1 <<< 19) - u;
    if (e > (64'sd1 <<< 19)) e = 64'sd1 <<< 19;
    if (e < -(64'sd1 <<< 19)) e = -(64'sd1 <<< 19);
    m_err[p][2] = m_err[p][1];
    m_err[p][1] = m_err[p][0];
    m_err[p][0] = e;
  endtask

  task automatic strobe(input longint x, input bit wide, input string tag);
    longint xm, xb, qa, qb, ga, gb;
    @(negedge clk);
    sample_in = x[IN_W-1:0];
    wide_mode = wide;
    ns_en = 1'b1;
    xm = wide ? x : (x & ~64'sd15);
    xb = (xm == -(64'sd1 <<< 23)) ? ((64'sd1 <<< 23) - 1) : -xm;
    model_step(0, xm, qa);
    model_step(1, xb, qb);
    @(negedge clk);
    ns_en = 1'b0;
    ga = longint'($signed(code_a));
    gb = longint'($signed(code_b));
    sum_a += ga;
    sum_b += gb;
    check(code_valid == 1'b1, "R2 valid after strobe", longint'(code_valid), 1);
    check(ga == qa, {tag, " path A"}, ga, qa);
    check(gb == qb, {tag, " path B"}, gb, qb);
    check(ga <= 15 && ga >= -15 && gb <= 15 && gb >= -15, "R3 code span", ga, qa);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint ha, hb, xv;
    real avg;
    model_clear();
    sum_a = 0;
    sum_b = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(code_a == '0 && code_b == '0, "R1 codes zero in reset", longint'($signed(code_a)), 0);
    check(code_valid == 1'b0, "R1 valid low in reset", longint'(code_valid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(code_valid == 1'b0, "R2 idle valid low", longint'(code_valid), 0);

    // R4 and R9: varied wave, full 24-bit words
    for (int i = 0; i < 200; i++) begin
      xv = longint'(0.6 * 8388607.0 * $sin(0.07 * i) + 0.2 * 8388607.0 * $sin(0.31 * i));
      strobe(xv, 1'b1, "R4 R9 wave");
    end

    // R2: hold with no strobe
    strobe(64'sd900000, 1'b1, "R4 step");
    ha = longint'($signed(code_a));
    hb = longint'($signed(code_b));
    repeat (4) @(negedge clk);
    check(longint'($signed(code_a)) == ha && longint'($signed(code_b)) == hb,
          "R2 codes hold without strobe", longint'($signed(code_a)), ha);
    check(code_valid == 1'b0, "R2 valid drops", longint'(code_valid), 0);

    // R7: DC average
    sum_a = 0;
    sum_b = 0;
    for (int i = 0; i < 512; i++) strobe(64'sd1730150, 1'b1, "R7 dc");
    avg = real'(sum_a) / 512.0;
    check(avg > 3.3 - 1.0 && avg < 3.3 + 1.0, "R7 average path A x100", longint'(avg * 100.0), 330);
    avg = real'(sum_b) / 512.0;
    check(avg > -3.3 - 1.0 && avg < -3.3 + 1.0, "R7 average path B x100", longint'(avg * 100.0), -330);

    // R5: 20-bit words with junk in the low bits
    for (int i = 0; i < 100; i++) begin
      xv = longint'(0.5 * 8388607.0 * $sin(0.11 * i)) | longint'(i % 16);
      strobe(xv, 1'b0, "R5 narrow words");
    end

    // R8 and R6: full scale at both polarities
    for (int i = 0; i < 64; i++) strobe((64'sd1 <<< 23) - 1, 1'b1, "R8 full positive");
    for (int i = 0; i < 64; i++) strobe(-(64'sd1 <<< 23), 1'b1, "R6 R8 full negative");
    for (int i = 0; i < 40; i++) strobe(longint'(i * 37000), 1'b1, "R8 recovery");

    // R1: mid-run reset clears loop state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(code_a == '0 && code_b == '0 && code_valid == 1'b0, "R1 mid-run reset",
          longint'($signed(code_a)), 0);
    rst = 1'b0;
    model_clear();
    strobe(64'sd0, 1'b1, "R1 zero after reset");

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule